// File: doc/BRIEF.md
# Strong/Weak Output Grant Arbiter

This block is the grant stage for one output port of an input-queued crossbar switch. Each of the N inputs sends it a two-bit request code for its virtual output queue toward this output. The code marks the request as strong, weak or absent. The block keeps one queue-length counter per input, which follows arrivals into and departures from that input's queue for this output. Once per slot, which is one clock cycle, it grants at most one input and tags the grant with a single bit that says whether it answers a strong or a weak request.

Priority is tiered. Request strength comes first. Within the winning strength class, the input that forms this slot's preferred pair with the output wins if it is requesting. Failing that, the requester with the longest non-zero queue count wins. Equal counts are resolved by circular order from a pointer that advances every slot.

A single free-running slot counter holds the scheduling state. It steps through the states SLOT_0 to SLOT_N-1 on every clock and wraps from SLOT_N-1 back to SLOT_0. Reset forces SLOT_0. The current state gives both the preferred input and the tie-break start point. The slot counter has no other transitions.

Top module: `swg_out_arbiter`

## Requirements
- R1: Each input i drives bits [2i+1:2i] of `req_code`. The code 2'b00 means no request, 2'b01 means a weak request, and 2'b10 or 2'b11 means a strong request. An input that is not requesting is never granted.
- R2: If any input makes a strong request, only strong requesters can be granted. `grant_strong` is 1 with a grant that answers a strong request and 0 with a grant that answers a weak request.
- R3: The slot index s is 0 in the first cycle after reset and increments by one each cycle modulo N. If input (OUT_IDX − s) mod N is in the winning class, it is granted regardless of its counter.
- R4: Otherwise, the grant goes to the winning-class requester whose queue counter is largest, provided that counter is greater than zero.
- R5: Equal largest counters are resolved in favour of the first such input in circular index order starting at s.
- R6: No grant is issued if no member of the winning class qualifies under R3 or R4. Weak requesters are not considered when any strong request is present.
- R7: A counter goes up by one on `arrive[i]` alone, goes down by one on `depart[i]` alone, and is unchanged when both are set. A decision uses the counter values held before that edge's update.
- R8: A counter holds at 2^CW−1 on further arrivals and holds at 0 on further departures.
- R9: `grant` is registered and reflects the inputs sampled at the preceding clock edge. It has at most one bit set, and it is all zero with `grant_strong` 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_code | input | 2*N | Two-bit request code per input |
| arrive | input | N | Cell arrival at input i for this output |
| depart | input | N | Cell departure from input i toward this output |
| grant | output | N | One-hot grant, registered |
| grant_strong | output | 1 | Grant answers a strong request |

## Verification
A request presented before clock edge k shows up as `grant` and `grant_strong` immediately after edge k. The bench sets its inputs on the falling edge and compares the outputs on the next falling edge, so it reads each result exactly one edge after the stimulus that caused it. An arrival or departure sampled at edge k first affects the decision made at edge k+1. The bench model applies its own counter update only after it has computed the expected grant for edge k. The model slot index starts at 0 on the first edge after reset and advances once per edge, so the preferred input and the tie pointer always line up with the design.

// File: rtl/swg_pkg.sv
package swg_pkg;

    typedef enum logic [1:0] {
        REQ_NONE   = 2'b00,
        REQ_WEAK   = 2'b01,
        REQ_STRONG = 2'b10
    } req_cls_e;

    function automatic req_cls_e decode_req(input logic [1:0] code);
        if (code[1])
            return REQ_STRONG;
        else if (code[0])
            return REQ_WEAK;
        else
            return REQ_NONE;
    endfunction

endpackage

// File: rtl/swg_qlen_ctr.sv
module swg_qlen_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] count_d;

    always_comb begin
        count_d = count;
        unique case ({inc, dec})
            2'b10:   if (count != CMAX) count_d = count + 1'b1;
            2'b01:   if (count != '0)   count_d = count - 1'b1;
            default: count_d = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= count_d;
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == CMAX && $past(inc) && !$past(dec)) |-> count == CMAX);
    // R8
    floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == '0 && $past(dec) && !$past(inc)) |-> count == '0);
    // R7
    both_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc) && $past(dec) && $past(rst_n)) |-> $stable(count));

endmodule

// File: rtl/swg_slot_ctr.sv
module swg_slot_ctr #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [IW-1:0] slot
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] slot_d;

    always_comb begin
        if (slot == LAST)
            slot_d = '0;
        else
            slot_d = slot + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else
            slot <= slot_d;
    end

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);

endmodule

// File: rtl/swg_pick.sv
module swg_pick #(
    parameter int N  = 4,
    parameter int CW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    mask,
    input  logic [N*CW-1:0] counts,
    input  logic [IW-1:0]   start,
    output logic            found,
    output logic [IW-1:0]   idx
);
    logic [CW-1:0] best_c;

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        best_c = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(start) + k) % N;
            if (mask[j] && counts[j*CW +: CW] != '0 &&
                (!found || counts[j*CW +: CW] > best_c)) begin
                found  = 1'b1;
                best_c = counts[j*CW +: CW];
                idx    = IW'(j);
            end
        end
    end

endmodule

// File: rtl/swg_out_arbiter.sv
module swg_out_arbiter #(
    parameter int N       = 4,
    parameter int CW      = 4,
    parameter int OUT_IDX = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*N-1:0] req_code,
    input  logic [N-1:0]   arrive,
    input  logic [N-1:0]   depart,
    output logic [N-1:0]   grant,
    output logic           grant_strong
);
    import swg_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0]   slot;
    logic [N*CW-1:0] counts;
    logic [N-1:0]    strong_m;
    logic [N-1:0]    weak_m;
    logic [N-1:0]    cls_m;
    logic            any_strong;
    logic [IW-1:0]   pref;
    logic            pick_found;
    logic [IW-1:0]   pick_idx;
    logic [N-1:0]    grant_d;
    logic            strong_d;

    swg_slot_ctr #(.N(N)) slot_i (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (slot)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        swg_qlen_ctr #(.CW(CW)) ctr_i (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (arrive[i]),
            .dec  (depart[i]),
            .count(counts[i*CW +: CW])
        );
        assign strong_m[i] = (decode_req(req_code[2*i +: 2]) == REQ_STRONG);
        assign weak_m[i]   = (decode_req(req_code[2*i +: 2]) == REQ_WEAK);
    end

    assign any_strong = |strong_m;
    assign cls_m      = any_strong ? strong_m : weak_m;
    assign pref       = IW'((OUT_IDX + N - int'(slot)) % N);

    swg_pick #(.N(N), .CW(CW)) pick_i (
        .mask  (cls_m),
        .counts(counts),
        .start (slot),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        grant_d  = '0;
        strong_d = 1'b0;
        if (cls_m[pref]) begin
            grant_d[pref] = 1'b1;
            strong_d      = any_strong;
        end else if (pick_found) begin
            grant_d[pick_idx] = 1'b1;
            strong_d          = any_strong;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant        <= '0;
            grant_strong <= 1'b0;
        end else begin
            grant        <= grant_d;
            grant_strong <= strong_d;
        end
    end

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2
    strong_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && $past(any_strong)) |-> grant_strong);
    // R2
    tag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> !grant_strong);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R1
        grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (grant_strong ? $past(req_code[2*i+1])
                                       : ($past(req_code[2*i +: 2]) == 2'b01)));
    end

endmodule

// File: tb/swg_out_arbiter_tb.sv
module swg_out_arbiter_tb_top;

    localparam int N       = 4;
    localparam int CW      = 4;
    localparam int OUT_IDX = 1;
    localparam int CMAX    = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] req_code = '0;
    logic [N-1:0]   arrive = '0;
    logic [N-1:0]   depart = '0;
    logic [N-1:0]   grant;
    logic           grant_strong;

    int checks = 0;
    int errors = 0;
    int m_slot = 0;
    int m_cnt [N];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swg_out_arbiter #(.N(N), .CW(CW), .OUT_IDX(OUT_IDX)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_code    (req_code),
        .arrive      (arrive),
        .depart      (depart),
        .grant       (grant),
        .grant_strong(grant_strong)
    );

    function automatic void expect_grant(input logic [2*N-1:0] rc,
                                         output logic [N-1:0] eg,
                                         output logic es);
        logic [N-1:0] sm, wm, cm;
        int pref, best, bi;
        sm = '0; wm = '0;
        for (int i = 0; i < N; i++) begin
            sm[i] = rc[2*i+1];
            wm[i] = (rc[2*i +: 2] == 2'b01);
        end
        cm = (|sm) ? sm : wm;
        eg = '0; es = 1'b0;
        pref = (OUT_IDX - m_slot + N) % N;
        if (cm[pref]) begin
            eg[pref] = 1'b1; es = |sm;
            return;
        end
        best = 0; bi = -1;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (m_slot + k) % N;
            if (cm[j] && m_cnt[j] > best) begin
                best = m_cnt[j]; bi = j;
            end
        end
        if (bi >= 0) begin
            eg[bi] = 1'b1; es = |sm;
        end
    endfunction

    function automatic void model_update(input logic [N-1:0] a, input logic [N-1:0] d);
        for (int i = 0; i < N; i++) begin
            if (a[i] && !d[i] && m_cnt[i] < CMAX) m_cnt[i]++;
            else if (d[i] && !a[i] && m_cnt[i] > 0) m_cnt[i]--;
        end
        m_slot = (m_slot + 1) % N;
    endfunction

    task automatic step(input logic [2*N-1:0] rc, input logic [N-1:0] a,
                        input logic [N-1:0] d, input string tag);
        logic [N-1:0] eg;
        logic es;
        expect_grant(rc, eg, es);
        model_update(a, d);
        req_code = rc; arrive = a; depart = d;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (grant !== eg || grant_strong !== es) begin
            errors++;
            $display("FAIL %s: grant=%b strong=%b expected grant=%b strong=%b",
                     tag, grant, grant_strong, eg, es);
        end
    endtask

    function automatic logic [2*N-1:0] code1(input int i, input logic [1:0] c);
        logic [2*N-1:0] r;
        r = '0;
        r[2*i +: 2] = c;
        return r;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (grant !== '0 || grant_strong !== 1'b0) begin
            errors++;
            $display("FAIL R9: reset grant=%b strong=%b expected grant=0000 strong=0",
                     grant, grant_strong);
        end
        rst_n = 1'b1;

        // R6: nobody has cells, weak requests away from preferred input
        step(8'b00_01_00_01, '0, '0, "R6");
        // R7: build counts, input 0 gets 3, input 2 gets 5
        for (int k = 0; k < 5; k++)
            step('0, (k < 3) ? 4'b0101 : 4'b0100, '0, "R7");
        // R1 / R4 weak requesters, length decides unless preferred
        for (int k = 0; k < 4; k++)
            step(8'b00_01_00_01, '0, '0, "R4");
        // R2: strong beats weak with a longer queue
        for (int k = 0; k < 4; k++)
            step(8'b00_01_00_10, '0, '0, "R2");
        // R1: code 11 is strong
        step(8'b11_00_00_01, '0, '0, "R1");
        // R3: preferred input wins even with zero count
        for (int k = 0; k < 4; k++)
            step(8'b10_10_10_10, '0, '0, "R3");
        // R7: simultaneous arrival and departure leaves count unchanged
        step('0, 4'b0001, 4'b0001, "R7");
        step('0, 4'b0100, 4'b0100, "R7");
        // R5: equalise input 0 and input 2 at 4 each, then tie
        step('0, 4'b0001, 4'b0100, "R7");
        for (int k = 0; k < 4; k++)
            step(8'b00_01_00_01, '0, '0, "R5");
        // R8: saturate input 3, drain input 0 below zero
        for (int k = 0; k < 20; k++)
            step('0, 4'b1000, 4'b0001, "R8");
        for (int k = 0; k < 4; k++)
            step(8'b01_00_00_01, '0, '0, "R8");
        for (int k = 0; k < 18; k++)
            step('0, 4'b0000, 4'b1000, "R8");
        for (int k = 0; k < 4; k++)
            step(8'b01_00_00_01, '0, '0, "R8");
        // R6: strong present, only zero-count strongs off preferred
        step(code1(3, 2'b10) | code1(2, 2'b01), '0, '0, "R6");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [2*N-1:0] rc;
            logic [N-1:0] a, d;
            rc = (2*N)'($urandom());
            a  = N'($urandom());
            d  = N'($urandom()) & N'($urandom());
            step(rc, a, d, "R3 R4 R5");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        #150000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule